// File: doc/BRIEF.md
# Posted-Write General-Purpose Timer

This block is a 32-bit up-counting timer on a simple word-addressed register bus. Software loads a start value, optionally a reload value and a compare value, and sets a run bit. The counter then advances once per timer tick, where a tick is one clock or, with the prescaler on, one clock in every 2^(ptv+1). When the counter passes 0xFFFFFFFF it raises an overflow flag. It then either reloads from the load register and keeps running, or wraps to zero and stops. A compare match raises a second flag. The flags are write-one-to-clear. A registered interrupt output and a registered wakeup output each report the flags that their enable registers select.

Writes to the control, counter, load, trigger and match registers are posted. Each such write sets its own bit in a pending-write status register. The write takes effect two clocks later, and the bit clears in that same cycle. Software polls the status register before it relies on the new value. A soft-reset request returns every register to its reset value and is visible in a reset-done status bit.

Top module: `pwt_top`

## Requirements
- R1: The revision register (offset 0x00) reads {24'b0, major[3:0], minor[3:0]} from parameters. Writes to it have no effect.
- R2: A write to control (0x24), counter (0x28), load (0x2C), trigger (0x30) or match (0x38) sets pending bit 0, 1, 2, 3 or 4 of the register at 0x34 on the write edge. The written value takes effect, and the bit clears, exactly 2 clock edges after the write edge.
- R3: While control bit 0 (run) is set and the prescaler is off, the counter (read at 0x28) increments by one on every clock.
- R4: On the tick after the counter holds 0xFFFFFFFF, interrupt status bit 1 (overflow) sets. With control bit 1 (auto-reload) set, the counter takes the load register value and keeps running.
- R5: With auto-reload clear, an overflow wraps the counter to 0 and clears control bit 0, so the counter stays at 0.
- R6: With control bit 6 (compare enable) set, the tick that brings the counter to the match register value sets status bit 0 (match). With compare enable clear, no match flag is raised.
- R7: Writing 1s to the interrupt status register (0x18) clears those bits on the write edge. Bits written as 0 are unchanged. Bit 2 (capture) always reads 0.
- R8: irq_o is high one clock after any status bit is set and enabled in 0x1C. wake_o does the same with the enables in 0x20. Both use bit positions match=0, overflow=1, capture=2.
- R9: With control bit 5 (prescaler enable) set, the counter advances once every 2^(ptv+1) clocks, ptv being control bits 4:2. The prescale count restarts when a control write takes effect.
- R10: A trigger write, once it takes effect, loads the counter from the load register.
- R11: Writing 1 to bit 1 of the config register (0x10) makes bit 0 of 0x14 (reset done) read 0 for one clock. On the next edge every register returns to its reset value and reset done reads 1 again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer and bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | AW (8) | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, valid while bus_rd is high |
| irq_o | output | 1 | Registered interrupt request |
| wake_o | output | 1 | Registered wakeup request |

## Verification
- **Registers written directly:** the status, enable and config registers change on the write edge.
- **Posted registers:** a posted register changes on the second edge after the write edge, and its pending bit is seen high after the first edge and low after the second.
- **Counter:** it first moves on the edge after a control write takes effect. An overflow or match flag appears on the edge of the counting tick, and irq_o or wake_o follows one edge later.

The bench drives each write around one known edge and reads the combinational read port between edges. It samples after exactly the number of edges these counts give. It also checks the value one edge early, so a result that comes too soon or too late is caught.

// File: rtl/pwt_pkg.sv
package pwt_pkg;
  localparam int unsigned NPOST = 5;
  // index of each posted register in the pending vector
  localparam int unsigned PI_CTRL  = 0;
  localparam int unsigned PI_CNT   = 1;
  localparam int unsigned PI_LOAD  = 2;
  localparam int unsigned PI_TRIG  = 3;
  localparam int unsigned PI_MATCH = 4;

  localparam logic [7:0] OFS_REV   = 8'h00;
  localparam logic [7:0] OFS_CFG   = 8'h10;
  localparam logic [7:0] OFS_SYS   = 8'h14;
  localparam logic [7:0] OFS_STS   = 8'h18;
  localparam logic [7:0] OFS_IEN   = 8'h1C;
  localparam logic [7:0] OFS_WEN   = 8'h20;
  localparam logic [7:0] OFS_CTRL  = 8'h24;
  localparam logic [7:0] OFS_CNT   = 8'h28;
  localparam logic [7:0] OFS_LOAD  = 8'h2C;
  localparam logic [7:0] OFS_TRIG  = 8'h30;
  localparam logic [7:0] OFS_WPS   = 8'h34;
  localparam logic [7:0] OFS_MATCH = 8'h38;

  // control bits
  localparam int unsigned CB_RUN  = 0;
  localparam int unsigned CB_AUTO = 1;
  localparam int unsigned CB_PTV  = 2;
  localparam int unsigned CB_PRE  = 5;
  localparam int unsigned CB_CMP  = 6;
  localparam int unsigned CTRL_W  = 7;

  // status / enable bits
  localparam int unsigned SB_MAT = 0;
  localparam int unsigned SB_OVF = 1;
  localparam int unsigned SB_CAP = 2;
  localparam int unsigned STS_W  = 3;

  localparam int unsigned CFG_W  = 10;
  localparam int unsigned CFG_SRST = 1;
endpackage

// File: rtl/pwt_post.sv
module pwt_post #(
  parameter int W     = 32,
  parameter int DELAY = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         srst,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  output logic         pend,
  output logic         commit,
  output logic [W-1:0] shadow
);
  localparam int AGW = (DELAY > 2) ? $clog2(DELAY) : 1;

  logic           pend_q, pend_d;
  logic [AGW-1:0] age_q, age_d;
  logic [W-1:0]   sh_q, sh_d;

  assign commit = pend_q && (age_q == '0) && !srst;
  assign pend   = pend_q;
  assign shadow = sh_q;

  always_comb begin
    pend_d = pend_q;
    age_d  = age_q;
    sh_d   = sh_q;
    if (commit)      pend_d = 1'b0;
    else if (pend_q) age_d  = age_q - 1'b1;
    if (wr) begin
      pend_d = 1'b1;
      age_d  = AGW'(DELAY - 1);
      sh_d   = wdata;
    end
    if (srst) begin
      pend_d = 1'b0;
      age_d  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      age_q  <= '0;
      sh_q   <= '0;
    end else begin
      pend_q <= pend_d;
      age_q  <= age_d;
      sh_q   <= sh_d;
    end
  end
endmodule

// File: rtl/pwt_count.sv
module pwt_count #(
  parameter int W  = 32,
  parameter int PW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          srst,
  input  logic          run,
  input  logic          auto_rl,
  input  logic          pre_en,
  input  logic [PW-1:0] ptv,
  input  logic          cmp_en,
  input  logic [W-1:0]  load_val,
  input  logic [W-1:0]  match_val,
  input  logic          ctrl_wr,
  input  logic          cnt_wr,
  input  logic [W-1:0]  cnt_wdata,
  input  logic          trg,
  output logic [W-1:0]  count,
  output logic          ovf_evt,
  output logic          mat_evt,
  output logic          stop_evt
);
  localparam int PCW = 2 ** PW;

  logic [PCW-1:0] pre_q, pre_d, pre_lim;
  logic [W-1:0]   cnt_q, cnt_d;
  logic           tick, at_top, busy;

  assign pre_lim  = PCW'((2 ** (32'(ptv) + 1)) - 1);
  assign tick     = run && (!pre_en || pre_q == pre_lim);
  assign at_top   = &cnt_q;
  assign busy     = cnt_wr || trg;
  assign ovf_evt  = tick && at_top && !busy;
  assign mat_evt  = tick && cmp_en && !at_top && !busy && ((cnt_q + 1'b1) == match_val);
  assign stop_evt = ovf_evt && !auto_rl;
  assign count    = cnt_q;

  always_comb begin
    pre_d = pre_q;
    if (ctrl_wr || tick || !run) pre_d = '0;
    else if (pre_en)             pre_d = pre_q + 1'b1;
    cnt_d = cnt_q;
    if (cnt_wr)    cnt_d = cnt_wdata;
    else if (trg)  cnt_d = load_val;
    else if (tick) cnt_d = at_top ? (auto_rl ? load_val : '0) : cnt_q + 1'b1;
    if (srst) begin
      pre_d = '0;
      cnt_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      cnt_q <= '0;
    end else begin
      pre_q <= pre_d;
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/pwt_top.sv
module pwt_top
  import pwt_pkg::*;
#(
  parameter int          AW        = 8,
  parameter int          DW        = 32,
  parameter int          POST_DLY  = 2,
  parameter logic [3:0]  REV_MAJOR = 4'h2,
  parameter logic [3:0]  REV_MINOR = 4'h1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  input  logic          bus_wr,
  input  logic          bus_rd,
  output logic [DW-1:0] bus_rdata,
  output logic          irq_o,
  output logic          wake_o
);
  localparam logic [7:0] POST_OFS [NPOST] = '{OFS_CTRL, OFS_CNT, OFS_LOAD, OFS_TRIG, OFS_MATCH};

  logic [NPOST-1:0] post_wr, post_pend, post_commit;
  logic [DW-1:0]    post_sh [NPOST];

  logic              srst_q, srst_d;
  logic [CTRL_W-1:0] ctrl_q, ctrl_d;
  logic [DW-1:0]     load_q, load_d, match_q, match_d;
  logic [STS_W-1:0]  sts_q, sts_d, ien_q, ien_d, wen_q, wen_d, sts_set, sts_clr;
  logic [CFG_W-1:0]  cfg_q, cfg_d;
  logic              irq_d, wake_d;
  logic [DW-1:0]     count;
  logic              ovf_evt, mat_evt, stop_evt;

  function automatic logic hit(input logic [AW-1:0] a, input logic [7:0] ofs);
    return a == AW'(ofs);
  endfunction

  for (genvar g = 0; g < NPOST; g++) begin : g_post
    assign post_wr[g] = bus_wr && hit(bus_addr, POST_OFS[g]);
    pwt_post #(.W(DW), .DELAY(POST_DLY)) u_post (
      .clk(clk), .rst_n(rst_n), .srst(srst_q), .wr(post_wr[g]), .wdata(bus_wdata),
      .pend(post_pend[g]), .commit(post_commit[g]), .shadow(post_sh[g])
    );
  end

  pwt_count #(.W(DW), .PW(3)) u_count (
    .clk(clk), .rst_n(rst_n), .srst(srst_q),
    .run(ctrl_q[CB_RUN]), .auto_rl(ctrl_q[CB_AUTO]), .pre_en(ctrl_q[CB_PRE]),
    .ptv(ctrl_q[CB_PTV +: 3]), .cmp_en(ctrl_q[CB_CMP]),
    .load_val(load_q), .match_val(match_q),
    .ctrl_wr(post_commit[PI_CTRL]), .cnt_wr(post_commit[PI_CNT]),
    .cnt_wdata(post_sh[PI_CNT]), .trg(post_commit[PI_TRIG]),
    .count(count), .ovf_evt(ovf_evt), .mat_evt(mat_evt), .stop_evt(stop_evt)
  );

  // next-state
  always_comb begin
    sts_set = '0;
    sts_set[SB_MAT] = mat_evt;
    sts_set[SB_OVF] = ovf_evt;
    sts_clr = (bus_wr && hit(bus_addr, OFS_STS)) ? bus_wdata[STS_W-1:0] : '0;

    srst_d  = bus_wr && hit(bus_addr, OFS_CFG) && bus_wdata[CFG_SRST];
    ctrl_d  = ctrl_q;
    if (post_commit[PI_CTRL]) ctrl_d = post_sh[PI_CTRL][CTRL_W-1:0];
    else if (stop_evt)        ctrl_d[CB_RUN] = 1'b0;
    load_d  = post_commit[PI_LOAD]  ? post_sh[PI_LOAD]  : load_q;
    match_d = post_commit[PI_MATCH] ? post_sh[PI_MATCH] : match_q;
    sts_d   = (sts_q & ~sts_clr) | sts_set;
    ien_d   = (bus_wr && hit(bus_addr, OFS_IEN)) ? bus_wdata[STS_W-1:0] : ien_q;
    wen_d   = (bus_wr && hit(bus_addr, OFS_WEN)) ? bus_wdata[STS_W-1:0] : wen_q;
    cfg_d   = cfg_q;
    if (bus_wr && hit(bus_addr, OFS_CFG)) begin
      cfg_d = bus_wdata[CFG_W-1:0];
      cfg_d[CFG_SRST] = 1'b0;
    end
    irq_d  = |(sts_q & ien_q);
    wake_d = |(sts_q & wen_q);
    if (srst_q) begin
      srst_d = 1'b0; ctrl_d = '0; load_d = '0; match_d = '0;
      sts_d = '0; ien_d = '0; wen_d = '0; cfg_d = '0; irq_d = 1'b0; wake_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      srst_q <= 1'b0; ctrl_q <= '0; load_q <= '0; match_q <= '0;
      sts_q <= '0; ien_q <= '0; wen_q <= '0; cfg_q <= '0;
      irq_o <= 1'b0; wake_o <= 1'b0;
    end else begin
      srst_q <= srst_d; ctrl_q <= ctrl_d; load_q <= load_d; match_q <= match_d;
      sts_q <= sts_d; ien_q <= ien_d; wen_q <= wen_d; cfg_q <= cfg_d;
      irq_o <= irq_d; wake_o <= wake_d;
    end
  end

  // read mux
  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      if (hit(bus_addr, OFS_REV))   bus_rdata = DW'({REV_MAJOR, REV_MINOR});
      if (hit(bus_addr, OFS_CFG))   bus_rdata = DW'(cfg_q | (CFG_W'(srst_q) << CFG_SRST));
      if (hit(bus_addr, OFS_SYS))   bus_rdata = DW'(!srst_q);
      if (hit(bus_addr, OFS_STS))   bus_rdata = DW'(sts_q);
      if (hit(bus_addr, OFS_IEN))   bus_rdata = DW'(ien_q);
      if (hit(bus_addr, OFS_WEN))   bus_rdata = DW'(wen_q);
      if (hit(bus_addr, OFS_CTRL))  bus_rdata = DW'(ctrl_q);
      if (hit(bus_addr, OFS_CNT))   bus_rdata = count;
      if (hit(bus_addr, OFS_LOAD))  bus_rdata = load_q;
      if (hit(bus_addr, OFS_WPS))   bus_rdata = DW'(post_pend);
      if (hit(bus_addr, OFS_MATCH)) bus_rdata = match_q;
    end
  end

  logic unused_bits;
  assign unused_bits = ^{post_sh[PI_CTRL][DW-1:CTRL_W], post_sh[PI_TRIG]};
endmodule

// File: rtl/pwt_sva.sv
module pwt_sva
  import pwt_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          srst_q,
  input logic [AW-1:0] bus_addr,
  input logic [DW-1:0] bus_wdata,
  input logic          bus_wr,
  input logic [4:0]    post_pend,
  input logic [4:0]    post_commit,
  input logic [6:0]    ctrl_q,
  input logic [DW-1:0] load_q,
  input logic [DW-1:0] count,
  input logic [2:0]    sts_q,
  input logic [2:0]    ien_q,
  input logic          ovf_evt,
  input logic          irq_o
);
  AST_PEND_HOLDS: assert property (@(posedge clk) disable iff (!rst_n || srst_q)
    $rose(post_pend[PI_CNT]) |=> post_pend[PI_CNT]); // R2

  AST_RELOAD: assert property (@(posedge clk) disable iff (!rst_n || srst_q)
    (ovf_evt && ctrl_q[CB_AUTO] && !post_commit[PI_CTRL]) |=>
      (count == $past(load_q) && ctrl_q[CB_RUN])); // R4

  AST_ONESHOT_STOP: assert property (@(posedge clk) disable iff (!rst_n || srst_q)
    (ovf_evt && !ctrl_q[CB_AUTO] && !post_commit[PI_CTRL]) |=>
      (count == '0 && !ctrl_q[CB_RUN])); // R5

  AST_W1C: assert property (@(posedge clk) disable iff (!rst_n || srst_q)
    (bus_wr && bus_addr == AW'(OFS_STS) && bus_wdata[SB_OVF] && !ovf_evt) |=> !sts_q[SB_OVF]); // R7

  AST_IRQ_LAG: assert property (@(posedge clk) disable iff (!rst_n || srst_q)
    $rose(irq_o) |-> $past(|(sts_q & ien_q))); // R8

  AST_SRST_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    srst_q |=> (!srst_q && ctrl_q == '0 && count == '0)); // R11
endmodule

bind pwt_top pwt_sva #(.AW(AW), .DW(DW)) u_sva (
  .clk(clk), .rst_n(rst_n), .srst_q(srst_q), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .bus_wr(bus_wr), .post_pend(post_pend), .post_commit(post_commit), .ctrl_q(ctrl_q),
  .load_q(load_q), .count(count), .sts_q(sts_q), .ien_q(ien_q), .ovf_evt(ovf_evt),
  .irq_o(irq_o)
);

// File: tb/pwt_top_tb.sv
module pwt_top_tb_top;
  import pwt_pkg::*;

  logic        clk, rst_n, bus_wr, bus_rd, irq_o, wake_o;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  int checks = 0, errors = 0;
  bit done = 0;

  pwt_top dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata), .irq_o(irq_o), .wake_o(wake_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  // drives a write that is sampled on the next rising edge (E0), returns after E0
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    bus_rd = 1'b0;
  endtask

  task automatic t_reset_rev;
    logic [31:0] v;
    rd(OFS_REV, v);  chk("R1 revision", v, 32'h21);
    rd(OFS_CNT, v);  chk("R1 counter reset", v, 0);
    rd(OFS_SYS, v);  chk("R11 reset done", v, 1);
    chk("R8 irq reset", {31'b0, irq_o}, 0);
    wr(OFS_REV, 32'hFFFF_FFFF); step(2);
    rd(OFS_REV, v);  chk("R1 revision write ignored", v, 32'h21);
  endtask

  task automatic t_posted;
    logic [31:0] v;
    wr(OFS_CNT, 32'h100);
    rd(OFS_WPS, v); chk("R2 pending after E0", v, 32'h2);
    rd(OFS_CNT, v); chk("R2 counter old after E0", v, 0);
    step(1);
    rd(OFS_WPS, v); chk("R2 pending after E1", v, 32'h2);
    rd(OFS_CNT, v); chk("R2 counter old after E1", v, 0);
    step(1);
    rd(OFS_WPS, v); chk("R2 pending cleared after E2", v, 0);
    rd(OFS_CNT, v); chk("R2 counter new after E2", v, 32'h100);
  endtask

  task automatic t_trigger;
    logic [31:0] v;
    wr(OFS_LOAD, 32'h55); step(2);
    wr(OFS_TRIG, 0);
    rd(OFS_WPS, v); chk("R10 trigger pending", v, 32'h8);
    step(1);
    rd(OFS_CNT, v); chk("R10 counter before trigger lands", v, 32'h100);
    step(1);
    rd(OFS_CNT, v); chk("R10 counter from load", v, 32'h55);
  endtask

  task automatic t_oneshot;
    logic [31:0] v;
    wr(OFS_IEN, 32'h2);
    wr(OFS_CNT, 32'hFFFF_FFFD); step(2);
    wr(OFS_CTRL, 32'h1);
    step(3);
    rd(OFS_CNT, v); chk("R3 count after first tick", v, 32'hFFFF_FFFE);
    step(1);
    rd(OFS_CNT, v); chk("R3 count at top", v, 32'hFFFF_FFFF);
    step(1);
    rd(OFS_CNT, v); chk("R5 wrapped to zero", v, 0);
    rd(OFS_STS, v); chk("R4 overflow flag", v, 32'h2);
    rd(OFS_CTRL, v); chk("R5 run bit cleared", v, 0);
    chk("R8 irq not yet", {31'b0, irq_o}, 0);
    step(1);
    chk("R8 irq one clock later", {31'b0, irq_o}, 1);
    step(3);
    rd(OFS_CNT, v); chk("R5 counter stays stopped", v, 0);
  endtask

  task automatic t_w1c;
    logic [31:0] v;
    wr(OFS_STS, 32'h0);
    rd(OFS_STS, v); chk("R7 zero write keeps flag", v, 32'h2);
    wr(OFS_STS, 32'h2);
    rd(OFS_STS, v); chk("R7 one clears flag", v, 0);
    step(1);
    chk("R8 irq drops", {31'b0, irq_o}, 0);
  endtask

  task automatic t_autoreload;
    logic [31:0] v, c1;
    wr(OFS_LOAD, 32'hFFFF_FFF0);
    wr(OFS_CNT, 32'hFFFF_FFFE); step(2);
    wr(OFS_CTRL, 32'h3);
    step(3);
    rd(OFS_CNT, v); chk("R3 count at top", v, 32'hFFFF_FFFF);
    step(1);
    rd(OFS_CNT, v); chk("R4 reloaded", v, 32'hFFFF_FFF0);
    rd(OFS_CTRL, v); chk("R4 still running", v, 32'h3);
    step(1);
    rd(OFS_CNT, v); chk("R4 continues", v, 32'hFFFF_FFF1);
    wr(OFS_CTRL, 0); step(2);
    rd(OFS_CNT, c1); step(3);
    rd(OFS_CNT, v); chk("R3 stop holds counter", v, c1);
    wr(OFS_STS, 32'h7);
  endtask

  task automatic t_match;
    logic [31:0] v;
    wr(OFS_WEN, 32'h1);
    wr(OFS_MATCH, 32'h10);
    wr(OFS_CNT, 32'h0C); step(2);
    wr(OFS_CTRL, 32'h41);
    step(5);
    rd(OFS_STS, v); chk("R6 no match before", v, 0);
    step(1);
    rd(OFS_CNT, v); chk("R6 count reached match", v, 32'h10);
    rd(OFS_STS, v); chk("R6 match flag", v, 32'h1);
    chk("R8 wake not yet", {31'b0, wake_o}, 0);
    step(1);
    chk("R8 wake one clock later", {31'b0, wake_o}, 1);
    wr(OFS_CTRL, 0); step(2);
    wr(OFS_STS, 32'h7);
    wr(OFS_CNT, 32'h0C); step(2);
    wr(OFS_CTRL, 32'h1); step(12);
    rd(OFS_STS, v); chk("R6 compare disabled no flag", v, 0);
    wr(OFS_CTRL, 0); step(2);
  endtask

  task automatic t_prescale;
    logic [31:0] v;
    wr(OFS_CNT, 0); step(2);
    wr(OFS_CTRL, 32'h21);
    step(3);
    rd(OFS_CNT, v); chk("R9 ptv0 no tick yet", v, 0);
    step(1);
    rd(OFS_CNT, v); chk("R9 ptv0 first tick", v, 1);
    step(1);
    rd(OFS_CNT, v); chk("R9 ptv0 held", v, 1);
    step(1);
    rd(OFS_CNT, v); chk("R9 ptv0 second tick", v, 2);
    wr(OFS_CTRL, 0); step(2);
    wr(OFS_CNT, 0); step(2);
    wr(OFS_CTRL, 32'h25);
    step(5);
    rd(OFS_CNT, v); chk("R9 ptv1 no tick yet", v, 0);
    step(1);
    rd(OFS_CNT, v); chk("R9 ptv1 first tick", v, 1);
  endtask

  task automatic t_softreset;
    logic [31:0] v;
    wr(OFS_LOAD, 32'h77); wr(OFS_IEN, 32'h3); step(2);
    wr(OFS_CFG, 32'h2);
    rd(OFS_SYS, v); chk("R11 reset in progress", v, 0);
    step(1);
    rd(OFS_SYS, v); chk("R11 reset done", v, 1);
    rd(OFS_CNT, v); chk("R11 counter cleared", v, 0);
    rd(OFS_LOAD, v); chk("R11 load cleared", v, 0);
    rd(OFS_IEN, v); chk("R11 enables cleared", v, 0);
    rd(OFS_CTRL, v); chk("R11 control cleared", v, 0);
  endtask

  initial begin
    rst_n = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = '0; bus_wdata = '0;
    step(3);
    rst_n = 1'b1;
    step(1);
    t_reset_rev();
    t_posted();
    t_trigger();
    t_oneshot();
    t_w1c();
    t_autoreload();
    t_match();
    t_prescale();
    t_softreset();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 50000; i++) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual %0d expected %0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule